// File: doc/BRIEF.md
# Parallel Probabilistic Bit-Flip LDPC Decoder

This block decodes a hard-decision word that was received over a binary symmetric channel and protected by a small regular low-density parity-check code with variable degree 3. A start pulse loads the received word. The decoder checks the parity of that word first and then runs one full decoding iteration per clock. In each iteration every parity check is formed as an XOR. Each variable node then decides by itself whether to invert its bit, using only its local energy and a pseudo-random bit. There is no search across nodes for a maximum energy, so the logic depth per iteration does not grow with the code length.

Energy is the sum of two terms: whether the bit now differs from the received bit, and how many of its three checks fail. The energy sets the chance that the bit flips. It never flips at energy 0, it always flips at the top energy, and it flips with a small, medium or large chance at the levels between. Decoding stops when every check is satisfied or when the iteration budget runs out. The decoder then pulses done and presents the word, a success flag and the number of iterations it used.

Top module: `ppbf_decoder`

## Requirements
- R1: After synchronous reset, done_o, ok_o, iters_o and word_o are all zero.
- R2: A start pulse while idle captures word_i as both the received word and the working word. If that word already satisfies every check, the decoder completes with ok_o=1, iters_o=0, and word_o equal to word_i.
- R3: The code has N=12 variables and M=6 checks. Check m is the XOR of the variables that feed it. Variable n feeds one check in each layer l = 0, 1, 2. That check is l*2 + ((n*a_l) mod 12)/6, where a_0=1, a_1=5 and a_2=7. Whenever ok_o=1 at done, word_o satisfies every check.
- R4: One iteration takes one clock. done_o rises exactly iters_o+1 rising edges after the edge that accepted start.
- R5: Decoding stops at the first parity evaluation that finds all checks satisfied, or when the count reaches MAX_ITER, whichever comes first. ok_o=0 at done only when iters_o equals MAX_ITER. iters_o never exceeds MAX_ITER.
- R6: With MAX_ITER=0, a word that fails a check comes back unchanged, with ok_o=0 and iters_o=0.
- R7: A start pulse that arrives while a decode is in progress is ignored.
- R8: Energy is (working bit XOR received bit) plus the number of failing checks of that variable, so its range is 0 to 4. A variable at energy 0 keeps its value, and a variable at energy 4 always flips.
- R9: done_o is a single-cycle pulse. word_o, ok_o and iters_o hold their values until the next decode completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load word_i and begin decoding (idle only) |
| word_i | input | 12 | Received hard-decision word |
| done_o | output | 1 | One-cycle completion pulse |
| word_o | output | 12 | Decoded word |
| ok_o | output | 1 | 1 when the final word satisfies every check |
| iters_o | output | ITER_W | Iterations used by the last decode |

## Verification
The hardest situation to create from the ports is a decode that stops at the budget limit. The pseudo-random flips usually repair a noisy word quickly, so a failing run cannot be forced with a main-instance stimulus. The bench therefore adds a second instance with a budget of zero. That instance must return a noisy word untouched, with failure reported. On the main instance the bench never predicts individual flips. For every noisy word it checks that success implies a word that passes its own independently built parity checks, that failure implies an exhausted budget, and that the latency matches the reported iteration count. To test that a second start is ignored, the bench pulses start with a valid codeword while a noisy word is still being decoded. If that pulse were accepted, the run would end with zero iterations.

// File: rtl/ppbf_pkg.sv
package ppbf_pkg;

    // Code dimensions: regular code, variable degree 3.
    localparam int unsigned CODE_N  = 12;
    localparam int unsigned CODE_DC = 6;
    localparam int unsigned CODE_DV = 3;
    localparam int unsigned CODE_Q  = CODE_N / CODE_DC;   // checks per layer
    localparam int unsigned CODE_M  = CODE_Q * CODE_DV;
    localparam int unsigned EN_W    = $clog2(CODE_DV + 2);

    typedef enum logic {
        DEC_IDLE = 1'b0,
        DEC_RUN  = 1'b1
    } dec_state_e;

    // Permutation multiplier of each layer (coprime with CODE_N).
    function automatic int unsigned layer_mult(input int unsigned l);
        case (l)
            0:       return 1;
            1:       return 5;
            default: return 7;
        endcase
    endfunction

    // Check index fed by variable n in layer l.
    function automatic int unsigned check_of(input int unsigned n, input int unsigned l);
        return l * CODE_Q + ((n * layer_mult(l)) % CODE_N) / CODE_DC;
    endfunction

    function automatic logic in_check(input int unsigned m, input int unsigned n);
        logic hit;
        hit = 1'b0;
        for (int unsigned l = 0; l < CODE_DV; l++)
            if (check_of(n, l) == m) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/ppbf_rand_src.sv
module ppbf_rand_src #(
    parameter int unsigned POOL_W = 12,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [POOL_W-1:0] pool_o
);
    logic [15:0] lfsr_q;
    logic        fb;
    logic        biased;

    assign fb     = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
    // Three independent taps ANDed: about one in eight is high.
    assign biased = lfsr_q[0] & lfsr_q[5] & lfsr_q[11];

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= (SEED == 16'h0) ? 16'h1 : SEED;
            pool_o <= '0;
        end else begin
            lfsr_q <= {lfsr_q[14:0], fb};
            pool_o <= {pool_o[POOL_W-2:0], biased};
        end
    end

endmodule

// File: rtl/ppbf_checks.sv
module ppbf_checks
    import ppbf_pkg::*;
(
    input  logic [CODE_N-1:0] v_i,
    output logic [CODE_M-1:0] chk_o,
    output logic              all_ok_o
);
    for (genvar m = 0; m < CODE_M; m++) begin : g_chk
        always_comb begin
            chk_o[m] = 1'b0;
            for (int unsigned n = 0; n < CODE_N; n++)
                if (in_check(m, n)) chk_o[m] = chk_o[m] ^ v_i[n];
        end
    end

    assign all_ok_o = (chk_o == '0);

endmodule

// File: rtl/ppbf_vnode.sv
module ppbf_vnode
    import ppbf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               upd_i,
    input  logic               ch_i,
    input  logic [CODE_DV-1:0] chk_i,
    input  logic [1:0]         rnd_i,
    output logic               v_o
);
    logic            y_q;
    logic [EN_W-1:0] energy;
    logic            flip;

    always_comb begin
        energy = EN_W'(v_o ^ y_q);
        for (int unsigned l = 0; l < CODE_DV; l++)
            energy = energy + EN_W'(chk_i[l]);
    end

    // Chance grows with energy: never, ~1/64, ~1/8, ~7/8, always.
    always_comb begin
        case (energy)
            EN_W'(0): flip = 1'b0;
            EN_W'(1): flip = rnd_i[0] & rnd_i[1];
            EN_W'(2): flip = rnd_i[0];
            EN_W'(3): flip = ~rnd_i[0];
            default:  flip = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= 1'b0;
            v_o <= 1'b0;
        end else if (load_i) begin
            y_q <= ch_i;
            v_o <= ch_i;
        end else if (upd_i) begin
            v_o <= v_o ^ flip;
        end
    end

    assert_cold_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !load_i && energy == EN_W'(0)) |=> (v_o == $past(v_o)));

    assert_hot_flip_R8: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !load_i && energy == EN_W'(CODE_DV + 1)) |=> (v_o != $past(v_o)));

endmodule

// File: rtl/ppbf_decoder.sv
module ppbf_decoder
    import ppbf_pkg::*;
#(
    parameter int unsigned MAX_ITER = 20,
    parameter int unsigned POOL_W   = 12,
    parameter logic [15:0] SEED     = 16'hACE1,
    localparam int unsigned ITER_W  = $clog2(MAX_ITER + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CODE_N-1:0] word_i,
    output logic              done_o,
    output logic [CODE_N-1:0] word_o,
    output logic              ok_o,
    output logic [ITER_W-1:0] iters_o
);
    dec_state_e        state_q;
    logic [ITER_W-1:0] iter_q;
    logic [CODE_N-1:0] vcur;
    logic [CODE_M-1:0] chk;
    logic              syn_ok;
    logic [POOL_W-1:0] pool;
    logic              load, run, at_limit, finish, upd;

    assign load     = (state_q == DEC_IDLE) && start_i;
    assign run      = (state_q == DEC_RUN);
    assign at_limit = (iter_q == ITER_W'(MAX_ITER));
    assign finish   = run && (syn_ok || at_limit);
    assign upd      = run && !syn_ok && !at_limit;

    ppbf_rand_src #(.POOL_W(POOL_W), .SEED(SEED)) u_rand (
        .clk    (clk),
        .rst    (rst),
        .pool_o (pool)
    );

    ppbf_checks u_checks (
        .v_i      (vcur),
        .chk_o    (chk),
        .all_ok_o (syn_ok)
    );

    for (genvar n = 0; n < CODE_N; n++) begin : g_vn
        logic [CODE_DV-1:0] nb;
        for (genvar l = 0; l < CODE_DV; l++) begin : g_nb
            assign nb[l] = chk[check_of(n, l)];
        end
        ppbf_vnode u_vn (
            .clk    (clk),
            .rst    (rst),
            .load_i (load),
            .upd_i  (upd),
            .ch_i   (word_i[n]),
            .chk_i  (nb),
            .rnd_i  ({pool[n % POOL_W], pool[(n + POOL_W / 2) % POOL_W]}),
            .v_o    (vcur[n])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DEC_IDLE;
            iter_q  <= '0;
            done_o  <= 1'b0;
            word_o  <= '0;
            ok_o    <= 1'b0;
            iters_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (load) begin
                state_q <= DEC_RUN;
                iter_q  <= '0;
            end else if (finish) begin
                state_q <= DEC_IDLE;
                done_o  <= 1'b1;
                word_o  <= vcur;
                ok_o    <= syn_ok;
                iters_o <= iter_q;
            end else if (upd) begin
                iter_q <= iter_q + 1'b1;
            end
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == DEC_IDLE) |=> $stable(word_o) && $stable(ok_o) && $stable(iters_o));

    assert_fail_at_limit_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ok_o) |-> (iters_o == ITER_W'(MAX_ITER)));

    assert_iter_bound_R5: assert property (@(posedge clk) disable iff (rst)
        iter_q <= ITER_W'(MAX_ITER));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (vcur == $past(word_i)));

    assert_success_codeword_R3: assert property (@(posedge clk) disable iff (rst)
        (done_o && ok_o) |-> $past(syn_ok));

endmodule

// File: tb/ppbf_decoder_bench.sv
module ppbf_decoder_bench;
    localparam int N = 12;
    localparam int K = 20;
    localparam int IW = $clog2(K + 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          start_a = 1'b0, start_b = 1'b0;
    logic [N-1:0]  win_a = '0, win_b = '0;
    logic          done_a, ok_a, done_b, ok_b;
    logic [N-1:0]  wout_a, wout_b;
    logic [IW-1:0] it_a;
    logic [0:0]    it_b;

    int checks = 0;
    int errors = 0;

    ppbf_decoder #(.MAX_ITER(K)) u_ppbf_decoder (
        .clk(clk), .rst(rst), .start_i(start_a), .word_i(win_a),
        .done_o(done_a), .word_o(wout_a), .ok_o(ok_a), .iters_o(it_a));

    ppbf_decoder #(.MAX_ITER(0)) u_ppbf_decoder_k0 (
        .clk(clk), .rst(rst), .start_i(start_b), .word_i(win_b),
        .done_o(done_b), .word_o(wout_b), .ok_o(ok_b), .iters_o(it_b));

    function automatic int chk_idx(int n, int l);
        int a;
        a = (l == 0) ? 1 : ((l == 1) ? 5 : 7);
        return l * 2 + ((n * a) % N) / 6;
    endfunction

    function automatic logic [5:0] syndrome(logic [N-1:0] w);
        logic [5:0] s;
        s = '0;
        for (int n = 0; n < N; n++)
            for (int l = 0; l < 3; l++)
                s[chk_idx(n, l)] = s[chk_idx(n, l)] ^ w[n];
        return s;
    endfunction

    task automatic check(input logic cond, input string req, input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run the main instance; optionally pulse start again one cycle later.
    task automatic run_a(input logic [N-1:0] w, input logic [N-1:0] w2, input bit second,
                         output logic [N-1:0] got, output logic ok, output int it, output int lat);
        @(negedge clk);
        win_a = w; start_a = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_a = 1'b0;
        lat = 0;
        if (second) begin win_a = w2; start_a = 1'b1; end
        for (int c = 0; c < 200; c++) begin
            @(posedge clk); lat++;
            @(negedge clk);
            start_a = 1'b0;
            if (done_a) break;
        end
        got = wout_a; ok = ok_a; it = int'(it_a);
    endtask

    task automatic t_reset;
        check(done_a == 0 && ok_a == 0 && it_a == 0 && wout_a == 0, "R1", {done_a, ok_a, it_a, wout_a}, 0);
        check(done_b == 0 && ok_b == 0 && wout_b == 0, "R1", {done_b, ok_b, wout_b}, 0);
    endtask

    task automatic t_codeword(input logic [N-1:0] w);
        logic [N-1:0] got; logic ok; int it, lat;
        run_a(w, '0, 0, got, ok, it, lat);
        check(got == w, "R2/R8 unchanged", got, w);
        check(ok == 1 && it == 0, "R2 ok/iters", {ok, it[7:0]}, 9'h100);
        check(lat == 1, "R4 latency", lat, 1);
        @(negedge clk);
        check(done_a == 0 && wout_a == w, "R9 pulse/hold", {done_a, wout_a}, w);
    endtask

    task automatic t_noisy(input logic [N-1:0] w);
        logic [N-1:0] got; logic ok; int it, lat;
        run_a(w, '0, 0, got, ok, it, lat);
        check(syndrome(w) != 0, "R3 stimulus noisy", syndrome(w), 1);
        if (ok) check(syndrome(got) == 0, "R3 success is codeword", syndrome(got), 0);
        else    check(it == K, "R5 failure at limit", it, K);
        check(it >= 1 && it <= K, "R5 iters range", it, K);
        check(lat == it + 1, "R4 latency", lat, it + 1);
    endtask

    task automatic t_busy(input logic [N-1:0] w);
        logic [N-1:0] got; logic ok; int it, lat;
        run_a(w, '0, 1, got, ok, it, lat);
        check(it >= 1, "R7 second start ignored", it, 1);
        check(lat == it + 1, "R7/R4 latency", lat, it + 1);
    endtask

    task automatic t_limit0(input logic [N-1:0] w);
        @(negedge clk);
        win_b = w; start_b = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_b = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(done_b == 1, "R6 done", done_b, 1);
        check(wout_b == w && ok_b == 0 && it_b == 0, "R6 unchanged/fail", {ok_b, it_b, wout_b}, w);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_codeword('0);
        t_codeword('1);
        t_noisy(12'h001);
        t_noisy(12'h080);
        t_noisy(12'h803);
        t_noisy(12'h0F0);
        t_noisy(12'hFFE);
        t_busy(12'h010);
        t_limit0(12'h004);
        t_limit0(12'h0A5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule